// File: doc/BRIEF.md
# Three-Level Physical-Address-Extension Page Walker

This block turns a 32-bit linear address into a 36-bit physical address by walking in-memory translation tables in the extended-physical-address format. Every table entry is 64 bits wide. The walk reads three levels in order:

- a four-entry pointer table whose base comes from a control register value;
- a page directory;
- a page table, unless the directory entry maps a 2 MB page.

Each read goes out on a 64-bit memory read port that allows any latency, and only one read is in flight at a time.

A requester hands over the linear address, the control-register value and an enable flag on a valid/ready handshake. The walker then works through the levels. It presents either the physical address or a not-present fault code, and holds that result until the requester acknowledges it. When the enable flag is low, no tables are read and the linear address passes through unchanged. The block accepts one request at a time.

Top module: `pae_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_rd` are 0.
- R2: The first read of a walk is at the pointer-table entry. Its address is `{4'b0, cr3[31:5], lin[31:30], 3'b000}`; bits 4..0 of `cr3` are ignored.
- R3: The second read is at the directory entry. Its address is `{ptr[35:12], lin[29:21], 3'b000}`, where `ptr` is the pointer entry just read; entry bits 63..36 are ignored.
- R4: If the directory entry is present and its bit 7 is 1, the walk ends after two reads. The result is `rsp_pa = {dir[35:21], lin[20:0]}`, with `rsp_large` = 1 and `rsp_fault` = 0.
- R5: Otherwise the third read is at `{dir[35:12], lin[20:12], 3'b000}`. If the table entry is present, the result is `rsp_pa = {tbl[35:12], lin[11:0]}`, with `rsp_large` = 0 and `rsp_fault` = 0.
- R6: Bit 0 of each entry is the present bit. If it is 0 at the pointer, directory or table level, the walk stops with no further reads. `rsp_fault` is then 1, 2 or 3 respectively, and `rsp_pa` is 0.
- R7: With `pae_en` low at acceptance, no memory read is issued. The result is `rsp_pa = {4'b0, lin}`, with `rsp_fault` = 0 and `rsp_large` = 0, and it is valid in the cycle after acceptance.
- R8: `req_ready` is 0 from acceptance until the response handshake. A response held with `rsp_ready` low keeps all of its fields stable.
- R9: Each read is a single-cycle `mem_rd` pulse. No new read is issued until `mem_rvalid` returns the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken on this cycle if valid |
| req_lin | input | 32 | Linear address to translate |
| req_cr3 | input | 32 | Control-register value; bits 31..5 locate the pointer table |
| pae_en | input | 1 | Extended translation enabled; low selects pass-through |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_addr | output | 36 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Entry contents |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken |
| rsp_pa | output | 36 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 ok, 1/2/3 not-present at pointer/directory/table level |
| rsp_large | output | 1 | Result came from a 2 MB mapping |

## Verification
The assertions take for granted that the memory side returns exactly one `mem_rvalid` for each `mem_rd` pulse, and never raises it while no read is outstanding. The bench's memory responder meets this: it answers only a strobe it has seen, after a latency that cycles through one to three cycles. The assertions also assume that the request inputs stay stable while `req_valid` waits for `req_ready`. The bench drives each request only when the walker is idle, and lowers it right after the handshake.

// File: rtl/pae_walker.sv
module pae_walker #(
  parameter int PA_W = 36
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_lin,
  input  logic [31:0]     req_cr3,
  input  logic            pae_en,
  output logic            mem_rd,
  output logic [PA_W-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [63:0]     mem_rdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_pa,
  output logic [1:0]      rsp_fault,
  output logic            rsp_large
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_t;

  st_t              st;
  logic [1:0]       lvl;
  logic [31:0]      lin_q;
  logic [26:0]      base_q;
  logic [PA_W-1:12] frm_q;
  logic [PA_W-1:0]  pa_q;
  logic [1:0]       fault_q;
  logic             large_q;

  assign req_ready = (st == S_IDLE);
  assign mem_rd    = (st == S_ISSUE);
  assign rsp_valid = (st == S_DONE);
  assign rsp_pa    = pa_q;
  assign rsp_fault = fault_q;
  assign rsp_large = large_q;

  always_comb begin
    case (lvl)
      2'd0:    mem_addr = {{(PA_W-32){1'b0}}, base_q, lin_q[31:30], 3'b000};
      2'd1:    mem_addr = {frm_q, lin_q[29:21], 3'b000};
      default: mem_addr = {frm_q, lin_q[20:12], 3'b000};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lvl     <= 2'd0;
      lin_q   <= '0;
      base_q  <= '0;
      frm_q   <= '0;
      pa_q    <= '0;
      fault_q <= 2'd0;
      large_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          lin_q   <= req_lin;
          base_q  <= req_cr3[31:5];
          lvl     <= 2'd0;
          fault_q <= 2'd0;
          large_q <= 1'b0;
          if (pae_en) begin
            st <= S_ISSUE;
          end else begin
            pa_q <= {{(PA_W-32){1'b0}}, req_lin};
            st   <= S_DONE;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          if (!mem_rdata[0]) begin
            fault_q <= lvl + 2'd1;
            pa_q    <= '0;
            st      <= S_DONE;
          end else if (lvl == 2'd1 && mem_rdata[7]) begin
            pa_q    <= {mem_rdata[PA_W-1:21], lin_q[20:0]};
            large_q <= 1'b1;
            st      <= S_DONE;
          end else if (lvl == 2'd2) begin
            pa_q <= {mem_rdata[PA_W-1:12], lin_q[11:0]};
            st   <= S_DONE;
          end else begin
            frm_q <= mem_rdata[PA_W-1:12];
            lvl   <= lvl + 2'd1;
            st    <= S_ISSUE;
          end
        end
        S_DONE: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R9
  AST_RVALID_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (st == S_WAIT)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_large)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid)); // R8
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> rsp_pa == '0 && !rsp_large); // R6
  AST_PASSTHRU_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !pae_en |=> rsp_valid && !mem_rd); // R7
  AST_PTR_LOW_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && lvl == 2'd0 |-> mem_addr[PA_W-1:32] == '0); // R2
  AST_LARGE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_large |-> rsp_fault == 2'd0); // R4

endmodule

// File: tb/pae_walker_tb.sv
module pae_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, pae_en = 1'b0, mem_rvalid = 1'b0, rsp_ready = 1'b0;
  logic [31:0] req_lin = '0, req_cr3 = '0;
  logic [63:0] mem_rdata = '0;
  logic        req_ready, mem_rd, rsp_valid, rsp_large;
  logic [35:0] mem_addr, rsp_pa;
  logic [1:0]  rsp_fault;

  always #2.5 clk = ~clk;

  pae_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .req_cr3(req_cr3), .pae_en(pae_en),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .rsp_large(rsp_large));

  int checks = 0, errors = 0;
  logic [63:0] mem [logic [35:0]];
  logic [35:0] exp_addr [$];
  string       exp_tag [$];
  logic [35:0] exp_pa;
  logic [1:0]  exp_fault;
  logic        exp_large;
  string       rsp_tag;
  bit          done = 0;

  function automatic logic [63:0] rd(input logic [35:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] lin, input logic [31:0] cr3, input bit pae);
    logic [35:0] a;
    logic [63:0] e;
    exp_addr.delete(); exp_tag.delete();
    exp_pa = '0; exp_fault = 0; exp_large = 0;
    if (!pae) begin exp_pa = {4'b0, lin}; rsp_tag = "R7"; return; end
    a = {4'b0, cr3[31:5], lin[31:30], 3'b000}; exp_addr.push_back(a); exp_tag.push_back("R2");
    e = rd(a);
    if (!e[0]) begin exp_fault = 1; rsp_tag = "R6"; return; end
    a = {e[35:12], lin[29:21], 3'b000}; exp_addr.push_back(a); exp_tag.push_back("R3");
    e = rd(a);
    if (!e[0]) begin exp_fault = 2; rsp_tag = "R6"; return; end
    if (e[7]) begin exp_pa = {e[35:21], lin[20:0]}; exp_large = 1; rsp_tag = "R4"; return; end
    a = {e[35:12], lin[20:12], 3'b000}; exp_addr.push_back(a); exp_tag.push_back("R5");
    e = rd(a);
    if (!e[0]) begin exp_fault = 3; rsp_tag = "R6"; return; end
    exp_pa = {e[35:12], lin[11:0]}; rsp_tag = "R5";
  endtask

  // memory responder, latency cycles 1..3
  initial begin
    int pend = 0, latsel = 0;
    logic [35:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin mem_rvalid = 1'b1; mem_rdata = rd(paddr); end
      end
      if (rst_n && mem_rd) begin paddr = mem_addr; pend = 1 + (latsel % 3); latsel++; end
    end
  end

  // per-cycle comparison against the model
  initial begin
    bit prev_rd = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mem_rd) begin
          if (exp_addr.size() == 0) chk(0, "R9 unexpected read", {28'd0, mem_addr}, 64'd0);
          else chk(mem_addr == exp_addr[0], exp_tag[0], {28'd0, mem_addr}, {28'd0, exp_addr[0]});
          if (exp_addr.size() != 0) begin void'(exp_addr.pop_front()); void'(exp_tag.pop_front()); end
          chk(!prev_rd, "R9 back-to-back read", 64'(prev_rd), 64'd0);
        end
        prev_rd = mem_rd;
        if (rsp_valid) begin
          chk(rsp_pa == exp_pa, {rsp_tag, " pa"}, {28'd0, rsp_pa}, {28'd0, exp_pa});
          chk(rsp_fault == exp_fault, {rsp_tag, " fault"}, 64'(rsp_fault), 64'(exp_fault));
          chk(rsp_large == exp_large, {rsp_tag, " large"}, 64'(rsp_large), 64'(exp_large));
          chk(!req_ready, "R8 ready while busy", 64'(req_ready), 64'd0);
        end
      end
    end
  end

  task automatic run(input logic [31:0] lin, input logic [31:0] cr3, input bit pae, input int hold);
    model(lin, cr3, pae);
    @(negedge clk);
    req_lin = lin; req_cr3 = cr3; pae_en = pae; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8 ready after accept", 64'(req_ready), 64'd0);
    while (!rsp_valid) @(negedge clk);
    repeat (hold) @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(exp_addr.size() == 0, {rsp_tag, " read count"}, 64'(exp_addr.size()), 64'd0);
  endtask

  localparam logic [31:0] CRA = 32'h0012_347F;
  localparam logic [31:0] CRB = 32'hFFFF_FFE0;
  localparam logic [31:0] L1 = 32'h4070_5ABC, L2 = 32'h8123_4567, L3 = 32'hC000_0000;
  localparam logic [31:0] L4 = 32'h0ABC_D123, L5 = 32'h4000_3000, L6 = 32'h3FFF_FFFF;

  initial begin
    mem[{4'b0, CRA[31:5], 2'd1, 3'b0}] = {28'h8000000, 36'h8_1234_5001};
    mem[{24'h812345, L1[29:21], 3'b0}] = {28'h0, 36'hA_BCDE_F003};
    mem[{24'hABCDEF, L1[20:12], 3'b0}] = {28'hFFFFFFF, 36'hF_0000_1007};
    mem[{4'b0, CRA[31:5], 2'd2, 3'b0}] = {28'h0, 36'h2_0000_0001};
    mem[{24'h200000, L2[29:21], 3'b0}] = {28'h0, 36'h7_6541_3083};
    mem[{4'b0, CRA[31:5], 2'd0, 3'b0}] = {28'h0, 36'h3_0000_0001};
    mem[{24'h812345, L5[29:21], 3'b0}] = {28'h0, 36'h5_5555_5001};
    mem[{24'h555555, L5[20:12], 3'b0}] = {28'h0, 36'h9_9999_9006};
    mem[{4'b0, CRB[31:5], 2'd0, 3'b0}] = {28'h0, 36'hA_0000_0001};
    mem[{24'hA00000, L6[29:21], 3'b0}] = {28'h0, 36'hF_FFE0_0081};

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk(mem_rd == 1'b0, "R1 mem_rd", 64'(mem_rd), 64'd0);
    rst_n = 1'b1;

    run(L1, CRA, 1, 0);   // R2 R3 R5 4K walk
    run(L2, CRA, 1, 0);   // R4 2M walk
    run(L3, CRA, 1, 0);   // R6 fault at pointer level
    run(L4, CRA, 1, 0);   // R6 fault at directory level
    run(L5, CRA, 1, 0);   // R6 fault at table level
    run(L1, CRA, 0, 0);   // R7 pass-through
    run(L1, CRA, 1, 5);   // R8 held response
    run(L6, CRB, 1, 2);   // R4 all-ones indices, high base
    run(L2, CRA, 0, 3);   // R7 R8 held pass-through
    run(L4, CRA, 1, 1);   // R9 latency variety
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule